// File: doc/BRIEF.md
# Burst Memory Target with Split Read and Write Channels

This block is a memory-backed target for a five-channel burst bus: a write address channel, a write data channel, a write response channel, a read address channel and a read data channel. Each channel has its own valid/ready pair. A transfer takes place on a rising clock edge where valid and ready are both high, whichever came first. Storage is an internal byte-lane array on a 32-bit data path. The block handles one write burst and one read burst at a time. The two directions run independently of each other, so a read can stream while a write is open.

A burst is described by its start address, a 4-bit length field (beats = length + 1), a 3-bit size field (bytes per beat = 2^size) and a 2-bit type field. Read beats carry a last marker on the final beat. A write burst ends with a single response. Every response carries the ID of the request it answers. Back-pressure works as follows. Every ready the block drives comes from registered state and never from the other side's valid. The block holds any valid it raises, with its payload frozen, until the matching ready arrives. The master may stall any channel for any number of cycles.

Top module: `axi_burst_mem`

## Requirements
- R1: Address requests are taken only while the same direction is idle (awready/arready high only then). At most one write burst and one read burst are open at any time.
- R2: Once rvalid or bvalid is raised it stays high, with ID, data, response and last marker unchanged, until the master's ready completes the handshake.
- R3: rid on every read beat equals the arid of its burst. bid equals the awid of its burst.
- R4: A read burst returns exactly length+1 beats, and rlast is high on the final beat only.
- R5: A write burst accepts exactly length+1 data beats. Exactly one response follows, and bvalid never rises before the final beat has been taken.
- R6: A write beat changes only the bytes whose wstrb bit is set. Bit i of wstrb covers wdata[8i+7:8i] at byte (beat address rounded down to 4) + i.
- R7: Type 2'b01 (incrementing): after each beat the address becomes the beat address rounded down to 2^size, plus 2^size.
- R8: Type 2'b00 (fixed): every beat uses the start address.
- R9: Type 2'b10 (wrapping): like incrementing, but when the address reaches the top of the window (length+1)·2^size bytes wide and aligned to that width around the start address, it returns to the bottom of that window.
- R10: A beat whose address lies at or beyond the memory size (256 bytes by default) writes nothing and reads as zero. Such a beat gets SLVERR (2'b10); every in-range beat gets OKAY (2'b00). A write response is SLVERR if any of its beats was out of range.
- R11: If wlast is missing on the final write beat, or appears on an earlier beat, the response is SLVERR. The burst still ends after length+1 beats, and in-range beats are still written.
- R12: An illegal request returns SLVERR on every beat and writes nothing, but all length+1 beats are still exchanged. A request is illegal if its size exceeds the bus width, its type is 2'b11, or it wraps with a length other than 1, 3, 7 or 15.
- R13: While rst_n is low and on the first cycle after its release, awready and arready are high and wready, bvalid and rvalid are low.
- R14: A read burst and a write burst to different addresses can be open at the same time, and neither disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| awid | input | ID_W | Write request ID |
| awaddr | input | ADDR_W | Write start byte address |
| awlen | input | 4 | Write beats minus one |
| awsize | input | 3 | Write log2 bytes per beat |
| awburst | input | 2 | Write burst type |
| awvalid | input | 1 | Write request valid |
| awready | output | 1 | Write request accepted |
| wdata | input | DATA_W | Write beat data |
| wstrb | input | DATA_W/8 | Write byte enables |
| wlast | input | 1 | Master's final-beat marker |
| wvalid | input | 1 | Write beat valid |
| wready | output | 1 | Write beat accepted |
| bid | output | ID_W | Response ID |
| bresp | output | 2 | Response code |
| bvalid | output | 1 | Response valid |
| bready | input | 1 | Response accepted |
| arid | input | ID_W | Read request ID |
| araddr | input | ADDR_W | Read start byte address |
| arlen | input | 4 | Read beats minus one |
| arsize | input | 3 | Read log2 bytes per beat |
| arburst | input | 2 | Read burst type |
| arvalid | input | 1 | Read request valid |
| arready | output | 1 | Read request accepted |
| rid | output | ID_W | Read beat ID |
| rdata | output | DATA_W | Read beat data |
| rresp | output | 2 | Read beat code |
| rlast | output | 1 | Final read beat |
| rvalid | output | 1 | Read beat valid |
| rready | input | 1 | Read beat accepted |

## Verification
The assertions assume the master obeys the handshake rules. It keeps each request and write beat steady while its valid waits for ready. It sends no write beats before a write request is accepted, and it offers at most length+1 beats per burst. The bench drives every channel from tasks that change inputs only on falling edges. Each task holds its valid until it has seen ready, supplies exactly the beat count it asked for, and sends concurrent reads and writes to disjoint regions, so none of these assumptions is broken. The stalls on rready and bready follow fixed rotating patterns. This exercises the hold checks without leaving legal master behaviour.

// File: rtl/axi_burst_mem_pkg.sv
package axi_burst_mem_pkg;

  typedef enum logic [1:0] {
    BT_FIXED = 2'b00,
    BT_INCR  = 2'b01,
    BT_WRAP  = 2'b10,
    BT_RSVD  = 2'b11
  } burst_e;

  localparam logic [1:0] RSP_OKAY   = 2'b00;
  localparam logic [1:0] RSP_SLVERR = 2'b10;

  // A request is usable when its beat fits the bus, its type is defined,
  // and a wrapping request spans a power-of-two beat count of 2..16.
  function automatic logic ctrl_ok(input logic [2:0] size, input logic [1:0] burst,
                                   input logic [3:0] len, input logic [2:0] size_max);
    logic wrap_len_ok;
    wrap_len_ok = (len == 4'd1) || (len == 4'd3) || (len == 4'd7) || (len == 4'd15);
    return (size <= size_max) && (burst != BT_RSVD) && ((burst != BT_WRAP) || wrap_len_ok);
  endfunction

endpackage

// File: rtl/axi_bm_addr_step.sv
module axi_bm_addr_step
  import axi_burst_mem_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [2:0]        size,
  input  logic [3:0]        len,
  input  logic [1:0]        burst,
  output logic [ADDR_W-1:0] nxt_addr
);

  logic [ADDR_W-1:0] beat_bytes;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] bumped;
  logic [ADDR_W-1:0] wrap_base;

  always_comb begin
    beat_bytes = ADDR_W'(1) << size;
    span       = ADDR_W'({1'b0, len} + 5'd1) << size;
    aligned    = cur_addr & ~(beat_bytes - ADDR_W'(1));
    bumped     = aligned + beat_bytes;
    wrap_base  = cur_addr & ~(span - ADDR_W'(1));
    case (burst)
      BT_FIXED: nxt_addr = cur_addr;
      BT_WRAP:  nxt_addr = (bumped == wrap_base + span) ? wrap_base : bumped;
      default:  nxt_addr = bumped;
    endcase
  end

endmodule

// File: rtl/axi_bm_store.sv
module axi_bm_store #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 64,
  parameter int LANES  = DATA_W / 8,
  parameter int IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  wstrb,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] cells [WORDS];

    always_ff @(posedge clk) begin
      if (we && wstrb[g]) cells[waddr] <= wdata[8*g +: 8];
    end

    assign rdata[8*g +: 8] = cells[raddr];
  end

endmodule

// File: rtl/axi_bm_wr_ctrl.sv
module axi_bm_wr_ctrl
  import axi_burst_mem_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 64,
  parameter int LANES  = DATA_W / 8,
  parameter int LANE_W = $clog2(LANES),
  parameter int IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   awid,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic [3:0]        awlen,
  input  logic [2:0]        awsize,
  input  logic [1:0]        awburst,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  wstrb,
  input  logic              wlast,
  input  logic              wvalid,
  output logic              wready,
  output logic [ID_W-1:0]   bid,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_wstrb
);

  localparam logic [2:0] SIZE_MAX = 3'(LANE_W);

  typedef enum logic [1:0] {WS_IDLE, WS_DATA, WS_RESP} wstate_e;

  wstate_e           st_q;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        len_q;
  logic [2:0]        size_q;
  logic [1:0]        burst_q;
  logic [3:0]        cnt_q;
  logic              ok_q;
  logic              err_q;
  logic [ADDR_W-1:0] nxt;
  logic              aw_hs, w_hs, b_hs;
  logic              beat_last, beat_hit, req_ok;

  axi_bm_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr(addr_q), .size(size_q), .len(len_q), .burst(burst_q), .nxt_addr(nxt)
  );

  assign awready   = (st_q == WS_IDLE);
  assign wready    = (st_q == WS_DATA);
  assign bvalid    = (st_q == WS_RESP);
  assign bid       = id_q;
  assign bresp     = err_q ? RSP_SLVERR : RSP_OKAY;
  assign aw_hs     = awvalid && awready;
  assign w_hs      = wvalid && wready;
  assign b_hs      = bvalid && bready;
  assign beat_last = (cnt_q == len_q);
  assign beat_hit  = (addr_q >> LANE_W) < ADDR_W'(WORDS);
  assign req_ok    = ctrl_ok(awsize, awburst, awlen, SIZE_MAX);

  assign mem_we    = w_hs && ok_q && beat_hit;
  assign mem_idx   = addr_q[LANE_W +: IDX_W];
  assign mem_wdata = wdata;
  assign mem_wstrb = wstrb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WS_IDLE;
      id_q    <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      size_q  <= '0;
      burst_q <= '0;
      cnt_q   <= '0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (st_q)
        WS_IDLE: if (aw_hs) begin
          id_q    <= awid;
          addr_q  <= awaddr;
          len_q   <= awlen;
          size_q  <= awsize;
          burst_q <= awburst;
          cnt_q   <= '0;
          ok_q    <= req_ok;
          err_q   <= !req_ok;
          st_q    <= WS_DATA;
        end
        WS_DATA: if (w_hs) begin
          addr_q <= nxt;
          cnt_q  <= cnt_q + 4'd1;
          if (!beat_hit || (wlast != beat_last)) err_q <= 1'b1;
          if (beat_last) st_q <= WS_RESP;
        end
        WS_RESP: if (b_hs) st_q <= WS_IDLE;
        default: st_q <= WS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/axi_bm_rd_ctrl.sv
module axi_bm_rd_ctrl
  import axi_burst_mem_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 64,
  parameter int LANES  = DATA_W / 8,
  parameter int LANE_W = $clog2(LANES),
  parameter int IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   arid,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [3:0]        arlen,
  input  logic [2:0]        arsize,
  input  logic [1:0]        arburst,
  input  logic              arvalid,
  output logic              arready,
  output logic [ID_W-1:0]   rid,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rlast,
  output logic              rvalid,
  input  logic              rready,
  output logic [IDX_W-1:0]  mem_idx,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam logic [2:0] SIZE_MAX = 3'(LANE_W);

  typedef enum logic {RS_IDLE, RS_SEND} rstate_e;

  rstate_e           st_q;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        len_q;
  logic [2:0]        size_q;
  logic [1:0]        burst_q;
  logic [3:0]        cnt_q;
  logic              ok_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        resp_q;
  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] look_addr;
  logic              look_ok, req_ok;
  logic              ar_hs, r_hs;

  axi_bm_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr(addr_q), .size(size_q), .len(len_q), .burst(burst_q), .nxt_addr(nxt)
  );

  // The beat about to be presented is fetched one edge ahead, so a stalled
  // beat sits in registers and cannot drift while rvalid waits.
  assign req_ok    = ctrl_ok(arsize, arburst, arlen, SIZE_MAX);
  assign look_addr = (st_q == RS_IDLE) ? araddr : nxt;
  assign look_ok   = ((st_q == RS_IDLE) ? req_ok : ok_q) &&
                     ((look_addr >> LANE_W) < ADDR_W'(WORDS));
  assign mem_idx   = look_addr[LANE_W +: IDX_W];

  assign arready = (st_q == RS_IDLE);
  assign rvalid  = (st_q == RS_SEND);
  assign rid     = id_q;
  assign rdata   = data_q;
  assign rresp   = resp_q;
  assign rlast   = (cnt_q == len_q);
  assign ar_hs   = arvalid && arready;
  assign r_hs    = rvalid && rready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RS_IDLE;
      id_q    <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      size_q  <= '0;
      burst_q <= '0;
      cnt_q   <= '0;
      ok_q    <= 1'b0;
      data_q  <= '0;
      resp_q  <= RSP_OKAY;
    end else begin
      case (st_q)
        RS_IDLE: if (ar_hs) begin
          id_q    <= arid;
          addr_q  <= araddr;
          len_q   <= arlen;
          size_q  <= arsize;
          burst_q <= arburst;
          cnt_q   <= '0;
          ok_q    <= req_ok;
          data_q  <= look_ok ? mem_rdata : '0;
          resp_q  <= look_ok ? RSP_OKAY : RSP_SLVERR;
          st_q    <= RS_SEND;
        end
        RS_SEND: if (r_hs) begin
          if (rlast) begin
            st_q <= RS_IDLE;
          end else begin
            addr_q <= nxt;
            cnt_q  <= cnt_q + 4'd1;
            data_q <= look_ok ? mem_rdata : '0;
            resp_q <= look_ok ? RSP_OKAY : RSP_SLVERR;
          end
        end
        default: st_q <= RS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/axi_burst_mem.sv
module axi_burst_mem #(
  parameter int ID_W      = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int MEM_BYTES = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ID_W-1:0]       awid,
  input  logic [ADDR_W-1:0]     awaddr,
  input  logic [3:0]            awlen,
  input  logic [2:0]            awsize,
  input  logic [1:0]            awburst,
  input  logic                  awvalid,
  output logic                  awready,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W/8-1:0]   wstrb,
  input  logic                  wlast,
  input  logic                  wvalid,
  output logic                  wready,
  output logic [ID_W-1:0]       bid,
  output logic [1:0]            bresp,
  output logic                  bvalid,
  input  logic                  bready,
  input  logic [ID_W-1:0]       arid,
  input  logic [ADDR_W-1:0]     araddr,
  input  logic [3:0]            arlen,
  input  logic [2:0]            arsize,
  input  logic [1:0]            arburst,
  input  logic                  arvalid,
  output logic                  arready,
  output logic [ID_W-1:0]       rid,
  output logic [DATA_W-1:0]     rdata,
  output logic [1:0]            rresp,
  output logic                  rlast,
  output logic                  rvalid,
  input  logic                  rready
);

  localparam int LANES = DATA_W / 8;
  localparam int WORDS = MEM_BYTES / LANES;
  localparam int IDX_W = $clog2(WORDS);

  logic              st_we;
  logic [IDX_W-1:0]  st_widx;
  logic [DATA_W-1:0] st_wdata;
  logic [LANES-1:0]  st_wstrb;
  logic [IDX_W-1:0]  st_ridx;
  logic [DATA_W-1:0] st_rdata;

  axi_bm_wr_ctrl #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)
  ) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awid(awid), .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
    .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bid(bid), .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .mem_we(st_we), .mem_idx(st_widx), .mem_wdata(st_wdata), .mem_wstrb(st_wstrb)
  );

  axi_bm_rd_ctrl #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)
  ) u_rd (
    .clk(clk), .rst_n(rst_n),
    .arid(arid), .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst),
    .arvalid(arvalid), .arready(arready),
    .rid(rid), .rdata(rdata), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready),
    .mem_idx(st_ridx), .mem_rdata(st_rdata)
  );

  axi_bm_store #(.DATA_W(DATA_W), .WORDS(WORDS)) u_store (
    .clk(clk), .we(st_we), .waddr(st_widx), .wdata(st_wdata), .wstrb(st_wstrb),
    .raddr(st_ridx), .rdata(st_rdata)
  );

endmodule

// File: rtl/axi_burst_mem_chk.sv
module axi_burst_mem_chk #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ID_W-1:0]   awid,
  input logic [3:0]        awlen,
  input logic              awvalid,
  input logic              awready,
  input logic              wvalid,
  input logic              wready,
  input logic [ID_W-1:0]   bid,
  input logic [1:0]        bresp,
  input logic              bvalid,
  input logic              bready,
  input logic [ID_W-1:0]   arid,
  input logic [3:0]        arlen,
  input logic              arvalid,
  input logic              arready,
  input logic [ID_W-1:0]   rid,
  input logic [DATA_W-1:0] rdata,
  input logic [1:0]        rresp,
  input logic              rlast,
  input logic              rvalid,
  input logic              rready
);

  logic aw_hs, w_hs, b_hs, ar_hs, r_hs;
  assign aw_hs = awvalid && awready;
  assign w_hs  = wvalid && wready;
  assign b_hs  = bvalid && bready;
  assign ar_hs = arvalid && arready;
  assign r_hs  = rvalid && rready;

  logic            wr_open, rd_open;
  logic [ID_W-1:0] aw_id_s, ar_id_s;
  logic [3:0]      aw_len_s, ar_len_s;
  logic [4:0]      w_cnt, r_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_open <= 1'b0; rd_open <= 1'b0;
      aw_id_s <= '0;   ar_id_s <= '0;
      aw_len_s <= '0;  ar_len_s <= '0;
      w_cnt <= '0;     r_cnt <= '0;
    end else begin
      if (aw_hs) begin
        wr_open <= 1'b1; aw_id_s <= awid; aw_len_s <= awlen; w_cnt <= '0;
      end else begin
        if (b_hs) wr_open <= 1'b0;
        if (w_hs) w_cnt <= w_cnt + 5'd1;
      end
      if (ar_hs) begin
        rd_open <= 1'b1; ar_id_s <= arid; ar_len_s <= arlen; r_cnt <= '0;
      end else begin
        if (r_hs && rlast) rd_open <= 1'b0;
        if (r_hs) r_cnt <= r_cnt + 5'd1;
      end
    end
  end

  // R1
  a_r1_one_write: assert property (@(posedge clk) disable iff (!rst_n) aw_hs |-> !wr_open);
  a_r1_one_read:  assert property (@(posedge clk) disable iff (!rst_n) ar_hs |-> !rd_open);
  // R2
  a_r2_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rid) && $stable(rresp) && $stable(rlast)));
  a_r2_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> (bvalid && $stable(bid) && $stable(bresp)));
  // R3
  a_r3_bid_echo: assert property (@(posedge clk) disable iff (!rst_n) bvalid |-> (bid == aw_id_s));
  a_r3_rid_echo: assert property (@(posedge clk) disable iff (!rst_n) rvalid |-> (rid == ar_id_s));
  // R4
  a_r4_rlast_pos: assert property (@(posedge clk) disable iff (!rst_n)
    r_hs |-> (rlast == (r_cnt == {1'b0, ar_len_s})));
  // R5
  a_r5_b_after_beats: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (w_cnt == {1'b0, aw_len_s} + 5'd1));
  a_r5_no_w_in_resp: assert property (@(posedge clk) disable iff (!rst_n) bvalid |-> !wready);
  // R10
  a_r10_bresp_code: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (bresp == 2'b00 || bresp == 2'b10));
  a_r10_rresp_code: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rresp == 2'b00 || rresp == 2'b10));

endmodule

bind axi_burst_mem axi_burst_mem_chk #(.ID_W(ID_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/axi_burst_mem_bench.sv
`timescale 1ns/1ps
module axi_burst_mem_bench;
  localparam int ID_W = 4, ADDR_W = 16, DATA_W = 32, MEM_BYTES = 256;

  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst_n;

  logic [ID_W-1:0] awid, arid, bid, rid;
  logic [ADDR_W-1:0] awaddr, araddr;
  logic [3:0] awlen, arlen, wstrb;
  logic [2:0] awsize, arsize;
  logic [1:0] awburst, arburst, bresp, rresp;
  logic awvalid, awready, wlast, wvalid, wready, bvalid, bready;
  logic arvalid, arready, rlast, rvalid, rready;
  logic [31:0] wdata, rdata;

  axi_burst_mem #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES)) u_axi_burst_mem (
    .clk(clk), .rst_n(rst_n),
    .awid(awid), .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
    .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bid(bid), .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .arid(arid), .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst),
    .arvalid(arvalid), .arready(arready),
    .rid(rid), .rdata(rdata), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready)
  );

  logic [7:0] model [MEM_BYTES];
  int total = 0, bad = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit legal(int size, int burst, int len);
    return size <= 2 && burst != 3 && (burst != 2 || len == 1 || len == 3 || len == 7 || len == 15);
  endfunction

  function automatic int next_addr(int a, int size, int len, int burst);
    int nb = 1 << size;
    int tot = (len + 1) * nb;
    int base = (a / tot) * tot;
    int n = (a / nb) * nb + nb;
    if (burst == 0) return a;
    if (burst == 2 && n >= base + tot) return base;
    return n & 16'hFFFF;
  endfunction

  function automatic string kind_tag(int burst);
    return burst == 0 ? "R8" : (burst == 1 ? "R7" : "R9");
  endfunction

  // mode: 0 correct wlast, 1 wlast on first beat, 2 wlast never
  task automatic do_write(int id, int addr, int len, int size, int burst, int mode, bit full, int seed);
    int a = addr;
    bit ok = legal(size, burst, len);
    bit err = !ok;
    bit early_b = 0;
    int k = 0;
    @(negedge clk);
    awid = ID_W'(id); awaddr = ADDR_W'(addr); awlen = 4'(len); awsize = 3'(size);
    awburst = 2'(burst); awvalid = 1'b1;
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 1'b0;
    for (int b = 0; b <= len; b++) begin
      logic [3:0] lanes, strb;
      logic [31:0] d;
      if (b % 3 == 2) begin wvalid = 1'b0; @(negedge clk); end
      for (int l = 0; l < 4; l++) d[8*l +: 8] = 8'(seed * 7 + b * 5 + l * 11 + 1);
      lanes = size > 2 ? 4'hF : 4'(((1 << (1 << size)) - 1) << (a % 4));
      strb = full ? 4'hF : lanes & ~4'(1 << ((seed + b) % 5));
      wdata = d; wstrb = strb;
      wlast = (mode == 0) ? (b == len) : (mode == 1) ? (b == 0) : 1'b0;
      wvalid = 1'b1;
      if (bvalid) early_b = 1;
      while (!wready) begin @(negedge clk); if (bvalid) early_b = 1; end
      if (ok && a < MEM_BYTES)
        for (int l = 0; l < 4; l++) if (strb[l]) model[(a & ~3) + l] = d[8*l +: 8];
      if (a >= MEM_BYTES) err = 1;
      if (wlast != (b == len)) err = 1;
      @(negedge clk);
      a = next_addr(a, size, len, burst);
    end
    wvalid = 1'b0; wlast = 1'b0;
    chk("R5", "response before final beat", early_b, 0);
    forever begin
      bready = ((k + seed) % 3) != 0;
      if (bvalid && bready) break;
      @(negedge clk);
      k++;
    end
    chk("R3", "bid", bid, id);
    chk(!ok ? "R12" : (mode != 0 ? "R11" : "R10"), "bresp", bresp, err ? 2 : 0);
    @(negedge clk);
    bready = 1'b0;
  endtask

  task automatic do_read(int id, int addr, int len, int size, int burst, int seed);
    int a = addr;
    bit ok = legal(size, burst, len);
    int k = 0;
    int b = 0;
    @(negedge clk);
    arid = ID_W'(id); araddr = ADDR_W'(addr); arlen = 4'(len); arsize = 3'(size);
    arburst = 2'(burst); arvalid = 1'b1;
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 1'b0;
    while (b <= len) begin
      rready = ((k + seed) % 4) != 1;
      if (rvalid && rready) begin
        bit hit = ok && a < MEM_BYTES;
        int w = a & ~3;
        logic [31:0] exp = hit ? {model[w+3], model[w+2], model[w+1], model[w]} : 32'h0;
        string tag = !ok ? "R12" : (a >= MEM_BYTES ? "R10" : kind_tag(burst));
        chk(tag, $sformatf("rdata beat %0d", b), rdata, exp);
        chk(tag, "rresp", rresp, hit ? 0 : 2);
        chk("R4", "rlast", rlast, b == len);
        chk("R3", "rid", rid, id);
        b++;
        a = next_addr(a, size, len, burst);
      end
      @(negedge clk);
      k++;
    end
    rready = 1'b0;
    chk("R4", "rvalid after final beat", rvalid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lens [5] = '{0, 1, 3, 7, 15};
    rst_n = 1'b0;
    awvalid = 0; wvalid = 0; bready = 0; arvalid = 0; rready = 0; wlast = 0;
    awid = 0; awaddr = 0; awlen = 0; awsize = 0; awburst = 0; wdata = 0; wstrb = 0;
    arid = 0; araddr = 0; arlen = 0; arsize = 0; arburst = 0;
    repeat (3) @(negedge clk);
    chk("R13", "awready in reset", awready, 1);
    chk("R13", "bvalid in reset", bvalid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13", "awready", awready, 1);
    chk("R13", "arready", arready, 1);
    chk("R13", "wready", wready, 0);
    chk("R13", "bvalid", bvalid, 0);
    chk("R13", "rvalid", rvalid, 0);

    // fill every word with known bytes
    for (int q = 0; q < 4; q++) do_write(q, q * 64, 15, 2, 1, 0, 1, q + 40);
    do_read(1, 0, 15, 2, 1, 0);

    // sweep burst type x size x length; R6 via rotating partial strobes
    for (int bt = 0; bt < 3; bt++)
      for (int sz = 0; sz < 3; sz++)
        for (int li = 0; li < 5; li++) begin
          int ad = ((bt * 37 + sz * 53 + li * 29) % 256) & ~((1 << sz) - 1);
          int id = (bt * 5 + sz * 3 + li) % 16;
          do_write(id, ad, lens[li], sz, bt, 0, 0, bt + sz + li);
          do_read(15 - id, ad, lens[li], sz, bt, li);
        end

    // R10: burst running off the end, and wholly outside
    do_write(3, 'hF8, 7, 2, 1, 0, 1, 9);
    do_read(4, 'hF8, 7, 2, 1, 2);
    do_write(5, 'h1000, 3, 2, 1, 0, 1, 11);
    do_read(6, 'h1000, 1, 2, 1, 0);

    // R12: illegal requests still consume every beat
    do_write(7, 'h10, 3, 3, 1, 0, 1, 13);
    do_write(8, 'h20, 3, 2, 3, 0, 1, 14);
    do_write(9, 'h30, 2, 2, 2, 0, 1, 15);
    do_read(10, 'h20, 3, 2, 3, 1);
    do_read(11, 'h30, 2, 2, 2, 3);
    do_read(12, 'h10, 3, 3, 1, 2);
    do_read(12, 'h10, 7, 2, 1, 0);

    // R11: early and missing wlast
    do_write(13, 'h40, 3, 2, 1, 1, 0, 17);
    do_write(14, 'h60, 3, 2, 1, 2, 1, 18);
    do_read(15, 'h40, 15, 2, 1, 3);

    // R14: concurrent read and write on disjoint regions
    fork
      do_write(2, 'h00, 7, 2, 1, 0, 1, 21);
      do_read(9, 'h80, 7, 2, 1, 1);
    join
    do_read(3, 'h00, 7, 2, 1, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule